// File: doc/BRIEF.md
# Pin Input/Output Controller with Per-Pin Interrupts

This block gives software a per-pin view of a bank of general-purpose pins through a 32-bit register interface with plain read and write strobes. Each pin can be driven from an output data register under its own output enable, and every pin's value is sampled through a two-stage synchronizer into a readable input register.

Each pin can also raise an interrupt in one of two ways. A level source is active while the synchronized pin matches a chosen polarity; it is not stored, so it follows the pin. An edge source latches an event bit on a chosen edge direction, and software clears the bit by writing a one to it. All enabled level and edge sources are ORed into bit 0 of a small top-level status register that sits in a second address region. A mask bit in that region gates the result onto one shared interrupt line.

The pin count is a parameter of at most 32. Register bits at or above that count read as zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero and `irq_out` is low.
- R2: In region 0, offset 0x04 holds the output data and offset 0x08 holds the output enables. `pin_out` and `pin_oe` show a written value from the clock edge that takes the write.
- R3: Region 0 offset 0x00 returns the pin values two clock edges after they change. Writes to this offset are ignored.
- R4: Region 0 offset 0x10 sets the level polarity per pin: a 0 bit means active while the pin is high, and a 1 bit means active while it is low. Offset 0x14 is the level mask. The level source equals (input XOR polarity) AND mask and is not latched.
- R5: Region 0 offset 0x24 sets the edge direction per pin: 0 selects rising edges and 1 selects falling edges. An event bit at offset 0x18 sets one edge after the synchronized pin changes in the selected direction, whatever the event mask holds.
- R6: Writing a 1 to a bit of offset 0x18 clears that event bit. A 0 bit in the written word leaves the event unchanged.
- R7: When a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R8: Offset 0x1C is the event mask. The edge source of a pin equals event AND event mask.
- R9: Region 1 offset 0x20 bit 0 reads the OR of all per-pin level and edge sources, and writes to it are ignored. Region 1 offset 0x24 bit 0 is the top-level mask. `irq_out` equals status bit 0 AND mask bit 0.
- R10: Bits at or above the pin count, and every unmapped offset, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_region | input | 1 | 0 selects the pin registers, 1 selects the top-level status/mask pair |
| reg_addr | input | 8 | Byte offset within the region |
| reg_wr | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from region and offset |
| pin_in | input | NPIN | Pin inputs, asynchronous |
| pin_out | output | NPIN | Output data to the pads |
| pin_oe | output | NPIN | Per-pin output enables |
| irq_out | output | 1 | Shared interrupt line |

## Verification
Two functions can act on the same event bit in the same cycle: a newly detected edge that sets it and a software write that clears it. The bench first lets an edge latch the bit. It then moves the pin away and back, and times the clearing write so that the write's clock edge is the edge that takes the second synchronized transition. The bit must read back as set, and a clearing write issued with no edge present must clear it, so a design that gives the clear priority fails the first read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned OFS_W = 8;

  // pin region offsets
  localparam logic [OFS_W-1:0] OFS_IN       = 8'h00;
  localparam logic [OFS_W-1:0] OFS_OUT      = 8'h04;
  localparam logic [OFS_W-1:0] OFS_OE       = 8'h08;
  localparam logic [OFS_W-1:0] OFS_LVL_POL  = 8'h10;
  localparam logic [OFS_W-1:0] OFS_LVL_MSK  = 8'h14;
  localparam logic [OFS_W-1:0] OFS_EVT      = 8'h18;
  localparam logic [OFS_W-1:0] OFS_EVT_MSK  = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_EDGE_POL = 8'h24;
  // top-level region offsets
  localparam logic [OFS_W-1:0] OFS_TOP_STS  = 8'h20;
  localparam logic [OFS_W-1:0] OFS_TOP_MSK  = 8'h24;

  typedef enum logic {REGION_PINS = 1'b0, REGION_TOP = 1'b1} region_e;

  // level source: active when the pin differs from its polarity bit
  function automatic logic [REG_W-1:0] level_src(input logic [REG_W-1:0] din,
                                                 input logic [REG_W-1:0] pol,
                                                 input logic [REG_W-1:0] msk);
    return (din ^ pol) & msk;
  endfunction

  // edge hit: pol 0 -> rising, pol 1 -> falling
  function automatic logic [REG_W-1:0] edge_sel(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] prev,
                                                input logic [REG_W-1:0] pol);
    return (~pol & cur & ~prev) | (pol & ~cur & prev);
  endfunction

  // event update: clear first, then set, so a set wins
  function automatic logic [REG_W-1:0] evt_next(input logic [REG_W-1:0] evt,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] set);
    return (evt & ~clr) | set;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_q,
  output logic [W-1:0] prev_q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  AST_PREV_TRAILS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(sync_q)); // R5
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] dir,
  input  logic         clr_valid,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] clr_eff;
  logic [REG_W-1:0] hit_wide;
  logic [REG_W-1:0] nxt_wide;

  assign hit_wide = edge_sel(REG_W'(cur), REG_W'(prev), REG_W'(dir));
  assign edge_hit = hit_wide[W-1:0];
  assign clr_eff  = clr_valid ? clr_bits : '0;
  assign nxt_wide = evt_next(REG_W'(evt_q), REG_W'(clr_eff), hit_wide);

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= nxt_wide[W-1:0];
  end

  AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((evt_q & $past(edge_hit)) == $past(edge_hit))); // R7

  AST_EVT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(edge_hit)) == '0)); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> ((evt_q & $past(clr_bits) & ~$past(edge_hit)) == '0)); // R6
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] lvl_pol,
  input  logic [W-1:0] lvl_msk,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] evt_msk,
  output logic [W-1:0] pin_irq,
  output logic         any_irq
);
  logic [REG_W-1:0] lvl_wide;
  logic [W-1:0]     edge_src;

  assign lvl_wide = level_src(REG_W'(din), REG_W'(lvl_pol), REG_W'(lvl_msk));
  assign edge_src = evt & evt_msk;
  assign pin_irq  = lvl_wide[W-1:0] | edge_src;
  assign any_irq  = |pin_irq;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_region,
  input  logic [7:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq_out
);
  localparam int unsigned W = NPIN;

  logic [W-1:0] dout_q, oe_q, lvl_pol_q, lvl_msk_q, evt_msk_q, edge_pol_q;
  logic         top_msk_q;
  logic [W-1:0] din_sync, din_prev, edge_hit, evt_q, pin_irq;
  logic         any_irq;
  logic         wr_pins, wr_top, evt_clr_wr;
  logic [W-1:0] wbits;

  assign wr_pins    = reg_wr && (reg_region == REGION_PINS);
  assign wr_top     = reg_wr && (reg_region == REGION_TOP);
  assign wbits      = reg_wdata[W-1:0];
  assign evt_clr_wr = wr_pins && (reg_addr == OFS_EVT);

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(pin_in),
    .sync_q(din_sync), .prev_q(din_prev)
  );

  gpio_evt_latch #(.W(W)) u_evt (
    .clk(clk), .rst_n(rst_n), .cur(din_sync), .prev(din_prev),
    .dir(edge_pol_q), .clr_valid(evt_clr_wr), .clr_bits(wbits),
    .edge_hit(edge_hit), .evt_q(evt_q)
  );

  gpio_irq_merge #(.W(W)) u_merge (
    .din(din_sync), .lvl_pol(lvl_pol_q), .lvl_msk(lvl_msk_q),
    .evt(evt_q), .evt_msk(evt_msk_q), .pin_irq(pin_irq), .any_irq(any_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q     <= '0;
      oe_q       <= '0;
      lvl_pol_q  <= '0;
      lvl_msk_q  <= '0;
      evt_msk_q  <= '0;
      edge_pol_q <= '0;
      top_msk_q  <= 1'b0;
    end else begin
      if (wr_pins) begin
        unique case (reg_addr)
          OFS_OUT:      dout_q     <= wbits;
          OFS_OE:       oe_q       <= wbits;
          OFS_LVL_POL:  lvl_pol_q  <= wbits;
          OFS_LVL_MSK:  lvl_msk_q  <= wbits;
          OFS_EVT_MSK:  evt_msk_q  <= wbits;
          OFS_EDGE_POL: edge_pol_q <= wbits;
          default: ;
        endcase
      end
      if (wr_top && reg_addr == OFS_TOP_MSK) top_msk_q <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_region == REGION_PINS) begin
      unique case (reg_addr)
        OFS_IN:       reg_rdata = REG_W'(din_sync);
        OFS_OUT:      reg_rdata = REG_W'(dout_q);
        OFS_OE:       reg_rdata = REG_W'(oe_q);
        OFS_LVL_POL:  reg_rdata = REG_W'(lvl_pol_q);
        OFS_LVL_MSK:  reg_rdata = REG_W'(lvl_msk_q);
        OFS_EVT:      reg_rdata = REG_W'(evt_q);
        OFS_EVT_MSK:  reg_rdata = REG_W'(evt_msk_q);
        OFS_EDGE_POL: reg_rdata = REG_W'(edge_pol_q);
        default:      reg_rdata = '0;
      endcase
    end else begin
      unique case (reg_addr)
        OFS_TOP_STS: reg_rdata = {31'd0, any_irq};
        OFS_TOP_MSK: reg_rdata = {31'd0, top_msk_q};
        default:     reg_rdata = '0;
      endcase
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = oe_q;
  assign irq_out = any_irq & top_msk_q;

  AST_OE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pins && reg_addr == OFS_OE) |=> pin_oe == $past(wbits)); // R2

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pin_irq != '0)); // R9

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> top_msk_q); // R9

  generate
    if (W < REG_W) begin : g_hi_zero
      AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:W] == '0); // R10
    end
  endgenerate
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_region = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.NPIN(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_region(reg_region), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic rg, input logic [7:0] a, input logic [31:0] d);
    reg_region = rg; reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic rg, input logic [7:0] a, output logic [31:0] d);
    reg_region = rg; reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // pins set at a negedge; after three negedges the event bit is also settled
  task automatic set_pins(input logic [NP-1:0] v);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 64; a += 4) begin
      rd(1'b0, 8'(a), v); chk("R1 pin region reset", v, 0);
      rd(1'b1, 8'(a), v); chk("R1 top region reset", v, 0);
    end
    chk("R1 pin_oe reset", 32'(pin_oe), 0);
    chk("R1 irq reset", 32'(irq_out), 0);

    // R2 outputs, R10 high bits
    wr(1'b0, 8'h04, 32'hFFFF_FFF5);
    chk("R2 pin_out", 32'(pin_out), 32'h5);
    rd(1'b0, 8'h04, v); chk("R10 dout high bits zero", v, 32'h5);
    for (int k = 0; k < 16; k++) begin
      wr(1'b0, 8'h08, 32'(k));
      chk("R2 pin_oe sweep", 32'(pin_oe), 32'(k));
    end
    rd(1'b0, 8'h0C, v); chk("R10 unmapped offset", v, 0);
    rd(1'b1, 8'h28, v); chk("R10 unmapped top offset", v, 0);

    // R3 synchronized input, two edges of latency
    pin_in = 4'hA;
    @(negedge clk);
    rd(1'b0, 8'h00, v); chk("R3 input one edge", v, 0);
    @(negedge clk);
    rd(1'b0, 8'h00, v); chk("R3 input two edges", v, 32'hA);
    wr(1'b0, 8'h00, 32'h5);
    rd(1'b0, 8'h00, v); chk("R3 input write ignored", v, 32'hA);
    set_pins(4'h0);
    wr(1'b0, 8'h18, 32'hF);                 // drop events from the pin steps

    // R4 / R9 level sweep
    wr(1'b1, 8'h24, 32'h1);
    for (int p = 0; p < NP; p++)
      for (int pol = 0; pol < 2; pol++)
        for (int val = 0; val < 2; val++) begin
          logic e;
          wr(1'b0, 8'h10, 32'(pol) << p);
          wr(1'b0, 8'h14, 32'h1 << p);
          set_pins(NP'(val) << p);
          e = 1'(val ^ pol);
          rd(1'b1, 8'h20, v); chk("R4 level status", v, 32'(e));
          chk("R9 irq_out level", 32'(irq_out), 32'(e));
          wr(1'b0, 8'h14, 0);
          rd(1'b1, 8'h20, v); chk("R4 level masked", v, 0);
        end
    set_pins(4'h0);
    wr(1'b0, 8'h10, 0);
    wr(1'b0, 8'h18, 32'hF);

    // R5 / R8 edge sweep
    for (int p = 0; p < NP; p++)
      for (int dir = 0; dir < 2; dir++) begin
        wr(1'b0, 8'h24, 32'(dir) << p);
        wr(1'b0, 8'h1C, 0);
        set_pins(NP'(1) << p);
        rd(1'b0, 8'h18, v); chk("R5 event after rise", v, (dir == 0) ? (32'h1 << p) : 0);
        rd(1'b1, 8'h20, v); chk("R8 masked event no status", v, 0);
        set_pins(4'h0);
        rd(1'b0, 8'h18, v); chk("R5 event after fall", v, 32'h1 << p);
        wr(1'b0, 8'h1C, 32'h1 << p);
        rd(1'b1, 8'h20, v); chk("R8 unmasked event status", v, 1);
        chk("R9 irq_out edge", 32'(irq_out), 1);
        wr(1'b0, 8'h18, ~(32'h1 << p));
        rd(1'b0, 8'h18, v); chk("R6 zero bits keep event", v, 32'h1 << p);
        wr(1'b1, 8'h20, 0);
        rd(1'b1, 8'h20, v); chk("R9 status write ignored", v, 1);
        wr(1'b1, 8'h24, 0);
        chk("R9 top mask gates irq", 32'(irq_out), 0);
        wr(1'b1, 8'h24, 1);
        wr(1'b0, 8'h18, 32'h1 << p);
        rd(1'b0, 8'h18, v); chk("R6 one clears event", v, 0);
        chk("R9 irq drops", 32'(irq_out), 0);
      end

    // R7 set beats clear in the same cycle
    wr(1'b0, 8'h24, 0);
    wr(1'b0, 8'h1C, 0);
    set_pins(4'h1);
    set_pins(4'h0);
    rd(1'b0, 8'h18, v); chk("R7 event primed", v, 1);
    pin_in = 4'h1;
    @(negedge clk);
    @(negedge clk);
    wr(1'b0, 8'h18, 32'h1);                 // taken on the edge that latches the new rise
    rd(1'b0, 8'h18, v); chk("R7 set wins over clear", v, 1);
    wr(1'b0, 8'h18, 32'h1);
    rd(1'b0, 8'h18, v); chk("R7 later clear works", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule